// File: doc/BRIEF.md
# Receive Frame Filter and Acknowledge Decision

This block follows a received low-rate wireless frame byte by byte and judges it once the last byte is in. It reports when a frame begins, when it ends and passes filtering, and whether the destination addressing names this node. It keeps a status bit holding the outcome of the trailing 16-bit frame check, and it asks for an automatic acknowledgement when every condition for one is met.

A frame begins with a start strobe that is qualified by a valid-header flag. It ends with a stop strobe, given in a cycle after the last data byte. Configuration inputs supply the node's short address, PAN identifier and 64-bit extended address. Three mode controls are also configuration inputs. Promiscuous mode drops the address and check requirements from the end event. A second control blocks acknowledgements. A two-bit mode caps the frame version that may be acknowledged.

Top module: `rx_frame_filter`

## Requirements
- R1: `evt_start` pulses for one cycle, one cycle after `rx_start` is sampled high together with `phr_ok`. A start strobe without `phr_ok` is ignored. The bytes and stop strobe that follow it then produce no event and leave `crc_ok` unchanged.
- R2: On the stop strobe, `crc_ok` takes the frame-check result. The check is CRC-16 with generator 0x1021, processed least significant bit first (reflected constant 0x8408) with initial value 0. It runs over every byte including the two FCS bytes, which are sent low byte first. The frame is good when the final remainder is zero.
- R3: A frame of fewer than 4 bytes sets `crc_ok` to 0 even when its remainder is zero. It never raises `evt_addr` or `ack_req`.
- R4: Second-level sanity requires at least 2 bytes, a frame type (byte 0 bits 2:0) of 0 to 3, and a frame version (byte 1 bits 5:4, which are frame control bits 13:12) other than 3. Without it, `evt_end` and `ack_req` stay low in every mode.
- R5: In normal mode (`cfg_prom`=0), `evt_end` pulses only for a sane frame with a good check that also matches the address.
- R6: In promiscuous mode, `evt_end` pulses for every sane frame, whatever its check result and its address.
- R7: Byte 2 is the sequence number. The destination addressing mode is byte 1 bits 3:2. For mode 2 the destination PAN is in bytes 3–4 and the short address in bytes 5–6. For mode 3 the destination PAN is in bytes 3–4 and the extended address in bytes 5–12. All fields are low byte first. `evt_addr` pulses, in both modes, when the PAN equals `cfg_pan` or 0xFFFF, the address equals the node's short address (or 0xFFFF) or its extended address, and two more bytes follow the address field. Modes 0 and 1 never match.
- R8: `ack_req` pulses only for a sane frame that has a good check, matches the address, and has acknowledge-request bit 5 of byte 0 set. It never pulses when the short destination is 0xFFFF.
- R9: While `cfg_ack_off` is 1, `ack_req` stays low.
- R10: `ack_req` additionally requires the frame version to be no greater than `cfg_ver_mode`. Mode 0 allows version 0, mode 1 allows 0–1, mode 2 allows 0–2, and mode 3 allows any version.
- R11: `evt_end`, `evt_addr`, `ack_req` and the new `crc_ok` all appear one cycle after the stop strobe is sampled. `crc_ok` holds its value at every other time and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_start | input | 1 | Frame start strobe |
| phr_ok | input | 1 | Header valid qualifier for `rx_start` |
| rx_valid | input | 1 | `rx_byte` carries a frame byte |
| rx_byte | input | 8 | Received byte |
| rx_stop | input | 1 | Frame end strobe, after the last byte |
| cfg_short | input | 16 | Node short address |
| cfg_pan | input | 16 | Node PAN identifier |
| cfg_ext | input | 64 | Node extended address |
| cfg_prom | input | 1 | Promiscuous mode enable |
| cfg_ack_off | input | 1 | Acknowledge disable |
| cfg_ver_mode | input | 2 | Highest frame version to acknowledge (3 = any) |
| evt_start | output | 1 | Frame start event pulse |
| evt_end | output | 1 | Frame end event pulse |
| evt_addr | output | 1 | Address match event pulse |
| crc_ok | output | 1 | Sticky frame-check status |
| ack_req | output | 1 | Acknowledge request pulse |

## Verification
The start event is due one cycle after the start strobe. Every end-of-frame result is due one cycle after the stop strobe, and they all appear together in that cycle. The bench drives each strobe on a falling edge, lets one rising edge register it, and reads the outputs on the next falling edge, inside the single cycle in which the pulses are high. Expected values come from a bench-side model of the requirements. That model rebuilds the CRC and the address rules from the bytes it sent.

// File: rtl/rx_frame_filter.sv
module rx_frame_filter #(
  parameter int CW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_start,
  input  logic        phr_ok,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_stop,
  input  logic [15:0] cfg_short,
  input  logic [15:0] cfg_pan,
  input  logic [63:0] cfg_ext,
  input  logic        cfg_prom,
  input  logic        cfg_ack_off,
  input  logic [1:0]  cfg_ver_mode,
  output logic        evt_start,
  output logic        evt_end,
  output logic        evt_addr,
  output logic        crc_ok,
  output logic        ack_req
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic          active;
  logic [CW-1:0] cnt;
  logic [15:0]   crc, dpan;
  logic [63:0]   daddr;
  logic [2:0]    f_type;
  logic          f_ar;
  logic [1:0]    f_dm, f_ver;
  logic [2:0]    ai;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction

  assign ai = cnt[2:0] - 3'd5;

  wire crc_good  = (cnt >= CW'(4)) && (crc == 16'h0000);
  wire sane      = (cnt >= CW'(2)) && !f_type[2] && (f_ver != 2'd3);
  wire pan_hit   = (dpan == cfg_pan) || (dpan == 16'hFFFF);
  wire bcast     = (f_dm == 2'd2) && (daddr[15:0] == 16'hFFFF);
  wire short_hit = (f_dm == 2'd2) && (cnt >= CW'(9)) && pan_hit &&
                   ((daddr[15:0] == cfg_short) || bcast);
  wire ext_hit   = (f_dm == 2'd3) && (cnt >= CW'(15)) && pan_hit && (daddr == cfg_ext);
  wire addr_hit  = short_hit || ext_hit;
  wire end_ok    = sane && (cfg_prom || (crc_good && addr_hit));
  wire ack_ok    = sane && crc_good && addr_hit && f_ar && !bcast &&
                   !cfg_ack_off && (f_ver <= cfg_ver_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; cnt <= '0; crc <= '0; dpan <= '0; daddr <= '0;
      f_type <= '0; f_ar <= 1'b0; f_dm <= '0; f_ver <= '0;
      evt_start <= 1'b0; evt_end <= 1'b0; evt_addr <= 1'b0;
      crc_ok <= 1'b0; ack_req <= 1'b0;
    end else begin
      evt_start <= 1'b0; evt_end <= 1'b0; evt_addr <= 1'b0; ack_req <= 1'b0;
      if (rx_start && phr_ok) begin
        active <= 1'b1; cnt <= '0; crc <= '0; dpan <= '0; daddr <= '0;
        f_type <= '0; f_ar <= 1'b0; f_dm <= '0; f_ver <= '0;
        evt_start <= 1'b1;
      end else if (active && rx_stop) begin
        active   <= 1'b0;
        crc_ok   <= crc_good;
        evt_end  <= end_ok;
        evt_addr <= addr_hit;
        ack_req  <= ack_ok;
      end else if (active && rx_valid) begin
        crc <= crc_step(crc, rx_byte);
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (cnt == CW'(0)) begin f_type <= rx_byte[2:0]; f_ar <= rx_byte[5]; end
        if (cnt == CW'(1)) begin f_dm <= rx_byte[3:2]; f_ver <= rx_byte[5:4]; end
        if (cnt == CW'(3)) dpan[7:0]  <= rx_byte;
        if (cnt == CW'(4)) dpan[15:8] <= rx_byte;
        if (cnt >= CW'(5) && cnt <= CW'(12)) daddr[{ai, 3'b000} +: 8] <= rx_byte;
      end
    end
  end

  assert_start_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |-> $past(rx_start && phr_ok));
  assert_ack_needs_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> (evt_addr && crc_ok && evt_end));
  assert_ack_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> !$past(cfg_ack_off));
  assert_normal_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_end && !$past(cfg_prom)) |-> (crc_ok && evt_addr));
  assert_status_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(active && rx_stop)) |-> $stable(crc_ok));
endmodule

// File: tb/rx_frame_filter_test.sv
module rx_frame_filter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_start = 0, phr_ok = 0, rx_valid = 0, rx_stop = 0;
  logic [7:0] rx_byte = 0;
  logic [15:0] cfg_short = 16'h1234, cfg_pan = 16'hBEEF;
  logic [63:0] cfg_ext = 64'h0102_0304_0506_0708;
  logic cfg_prom = 0, cfg_ack_off = 0;
  logic [1:0] cfg_ver_mode = 2'd3;
  logic evt_start, evt_end, evt_addr, crc_ok, ack_req;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] fb [0:31];
  int flen;
  logic exp_crc = 0;

  rx_frame_filter uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_of(input int n);
    logic [15:0] r = 16'h0;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++)
        r = (r[0] ^ fb[k][i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic build(input logic [2:0] typ, input logic ar, input logic [1:0] dm,
                       input logic [1:0] ver, input logic [15:0] pan,
                       input logic [63:0] addr, input int extra);
    fb[0] = {2'b00, ar, 2'b00, typ};
    fb[1] = {2'b00, ver, dm, 2'b00};
    fb[2] = 8'h5A;
    flen = 3;
    if (dm != 2'd0) begin
      fb[3] = pan[7:0]; fb[4] = pan[15:8]; flen = 5;
      for (int i = 0; i < ((dm == 2'd3) ? 8 : 2); i++) begin fb[flen] = addr[8*i +: 8]; flen++; end
    end
    for (int i = 0; i < extra; i++) begin fb[flen] = 8'(8'h30 + i); flen++; end
  endtask

  task automatic seal();
    logic [15:0] c = crc_of(flen);
    fb[flen] = c[7:0]; fb[flen+1] = c[15:8]; flen += 2;
  endtask

  task automatic run(input logic phr, input string tag);
    logic good, sane, panh, bc, hit, e_end, e_ack;
    logic [15:0] pan, sa;
    logic [63:0] ea;
    @(negedge clk); rx_start = 1; phr_ok = phr;
    @(negedge clk); rx_start = 0; phr_ok = 0;
    chk({"R1 start ", tag}, evt_start, phr);
    for (int k = 0; k < flen; k++) begin
      rx_valid = 1; rx_byte = fb[k]; @(negedge clk);
    end
    rx_valid = 0; rx_stop = 1;
    @(negedge clk); rx_stop = 0;
    good = (flen >= 4) && (crc_of(flen) == 16'h0);
    sane = (flen >= 2) && (fb[0][2:0] < 3'd4) && (fb[1][5:4] != 2'd3);
    pan = {fb[4], fb[3]}; sa = {fb[6], fb[5]};
    ea = {fb[12], fb[11], fb[10], fb[9], fb[8], fb[7], fb[6], fb[5]};
    panh = (pan == cfg_pan) || (pan == 16'hFFFF);
    bc = (fb[1][3:2] == 2'd2) && (sa == 16'hFFFF);
    hit = ((fb[1][3:2] == 2'd2) && flen >= 9 && panh && (sa == cfg_short || bc)) ||
          ((fb[1][3:2] == 2'd3) && flen >= 15 && panh && ea == cfg_ext);
    e_end = sane && (cfg_prom || (good && hit));
    e_ack = sane && good && hit && fb[0][5] && !bc && !cfg_ack_off && (fb[1][5:4] <= cfg_ver_mode);
    if (phr) exp_crc = good;
    else begin e_end = 0; hit = 0; e_ack = 0; end
    chk({"R2/R3/R11 crc_ok ", tag}, crc_ok, exp_crc);
    chk({"R4/R5/R6 evt_end ", tag}, evt_end, e_end);
    chk({"R7 evt_addr ", tag}, evt_addr, hit);
    chk({"R8/R9/R10 ack_req ", tag}, ack_req, e_ack);
    @(negedge clk);
    chk({"R11 pulse cleared ", tag}, evt_end | evt_addr | ack_req, 1'b0);
    chk({"R11 crc_ok held ", tag}, crc_ok, exp_crc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset crc_ok", crc_ok, 1'b0);
    chk("R1 reset evt_start", evt_start, 1'b0);
    chk("R8 reset ack_req", ack_req, 1'b0);
    rst_n = 1;
    // R10 R9 R8: version, mode, request bit and disable sweep on a matching short frame
    for (int v = 0; v < 4; v++)
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < 2; a++)
          for (int d = 0; d < 2; d++) begin
            cfg_ver_mode = 2'(m); cfg_ack_off = d[0];
            build(3'd1, a[0], 2'd2, 2'(v), cfg_pan, {48'h0, cfg_short}, 1); seal();
            run(1, "R10 sweep");
          end
    cfg_ver_mode = 2'd3; cfg_ack_off = 0;
    // R4: frame type sweep in both modes
    for (int p = 0; p < 2; p++)
      for (int t = 0; t < 8; t++) begin
        cfg_prom = p[0];
        build(3'(t), 1, 2'd2, 2'd1, cfg_pan, {48'h0, cfg_short}, 0); seal();
        run(1, "R4 type");
      end
    // R7 R5 R6: addressing variants in both modes, good and corrupted checks
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < 9; s++) begin
          cfg_prom = p[0];
          case (s)
            0: build(3'd1, 1, 2'd2, 2'd0, cfg_pan, {48'h0, cfg_short}, 2);
            1: build(3'd1, 1, 2'd2, 2'd0, cfg_pan, 64'h4321, 2);
            2: build(3'd1, 1, 2'd2, 2'd0, 16'h1111, {48'h0, cfg_short}, 2);
            3: build(3'd1, 1, 2'd2, 2'd0, 16'hFFFF, {48'h0, cfg_short}, 2);
            4: build(3'd1, 1, 2'd2, 2'd0, cfg_pan, 64'hFFFF, 2);
            5: build(3'd1, 1, 2'd3, 2'd1, cfg_pan, cfg_ext, 3);
            6: build(3'd1, 1, 2'd3, 2'd1, cfg_pan, cfg_ext ^ 64'h100, 3);
            7: build(3'd1, 1, 2'd0, 2'd0, 16'h0, 64'h0, 4);
            default: build(3'd1, 1, 2'd1, 2'd0, cfg_pan, {48'h0, cfg_short}, 2);
          endcase
          seal();
          if (c == 1) fb[flen-1] ^= 8'h01;
          run(1, "R7 addr");
        end
    // R3: frames too short, including a 3-byte one whose remainder is zero
    cfg_prom = 1;
    for (int n = 0; n < 3; n++) begin
      fb[0] = 8'h21; fb[1] = 8'h08; fb[2] = 8'h77; flen = n;
      run(1, "R3 short");
    end
    fb[0] = 8'h21; flen = 1; seal(); run(1, "R3 zero remainder");
    cfg_prom = 0;
    // R1: start without header qualifier leaves everything untouched
    build(3'd1, 1, 2'd2, 2'd0, cfg_pan, {48'h0, cfg_short}, 1); seal(); run(1, "R1 prime");
    build(3'd1, 1, 2'd2, 2'd0, cfg_pan, 64'h9999, 1); fb[flen] = 8'h00; flen++;
    run(0, "R1 unqualified");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule